// File: doc/BRIEF.md
# Framed Outgoing Packet Sequencer

The sequencer sits in front of a block-code encoder on a 16-bit transceiver-style lane. The lane carries two 8-bit symbols per clock, and each symbol has its own control-character flag. The sequencer turns a stream of buffered words, or an internally generated test stream, into fixed frames. A frame is one start-of-packet control beat followed by 239 payload symbols. Between frames the lane carries comma idles, so the far end keeps byte alignment.

A frame is launched only while the encoder's ready flag is high. Two launch policies are available. In host mode a one-cycle request pulse is remembered until the frame can go out. In automatic mode a frame leaves as soon as a whole frame's worth of data can be supplied. The source choice is captured at launch, so changing the selection mid-frame never mixes two streams.

Top module: `frame_sequencer`

## Requirements
- R1: While reset (rstN low, sampled on the clock) is asserted and on the first cycle after it, the lane shows the idle beat: both symbols 0xBC, txIsK = 2'b11, txValid = 2'b00, and fifoRd is low.
- R2: On every cycle that carries neither a start beat nor payload, both symbols are 0xBC with their K flags set and txValid = 2'b00.
- R3: A frame launches only in an idle cycle where encReady is high. The start beat appears on the next cycle: lane 0 (bits 7:0) is 0xFB, lane 1 is 0xBC, txIsK = 2'b11, txValid = 2'b00.
- R4: Exactly 120 payload beats follow the start beat, all with txIsK = 2'b00. The first 119 beats have txValid = 2'b11. The 120th beat has txValid = 2'b01 and a zero pad byte in bits 15:8, which gives 239 symbols in total.
- R5: With the buffer source latched, fifoRd is high in exactly the 120 cycles that precede the payload beats. Each payload beat equals the word presented on fifoData in the cycle before it, with bits 7:0 as the earlier symbol. On the last beat only bits 7:0 are kept.
- R6: With the pattern source latched, payload symbols form an incrementing 8-bit count. The count starts at 0 after reset, continues across frames (wrapping at 256), and fifoRd stays low.
- R7: In host mode, no frame launches without a request. A hostReq pulse is held until a launch takes place, including a pulse that arrives while a frame is in progress. The held request is cleared by the launch.
- R8: In automatic mode, a frame launches in every idle cycle in which encReady is high and data is available. Frames may follow each other back to back.
- R9: When the buffer source is selected, no launch happens unless fifoLevel is at least 120 words. This holds in both modes.
- R10: Changes to srcSelPattern, autoMode or encReady during a frame do not alter the frame in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low reset |
| srcSelPattern | input | 1 | 1 selects the pattern source, 0 the buffer |
| autoMode | input | 1 | 1 launches automatically, 0 waits for hostReq |
| hostReq | input | 1 | One-cycle launch request |
| encReady | input | 1 | Encoder can accept a new frame |
| fifoData | input | 16 | Head word of the buffer (show-ahead) |
| fifoLevel | input | 9 | Number of words held in the buffer |
| fifoRd | output | 1 | Pops the head word of the buffer |
| txData | output | 16 | Lane symbols, bits 7:0 sent first |
| txIsK | output | 2 | Per-symbol control-character flag |
| txValid | output | 2 | Per-symbol payload mask to the encoder |

## Verification
Two functions can fall in the same cycle: a host request and the launch decision that would consume it, or a request and the final beat of a frame. The bench fires a request while a frame is running and checks that the next start beat follows the 120th beat directly, and that exactly one extra frame results. It also toggles the source, mode and ready inputs in the middle of a frame, and checks every beat of that frame against a behavioural model that captures the source only at launch.

// File: rtl/frame_seq_pkg.sv
package frame_seq_pkg;

  typedef enum logic {
    ST_IDLE    = 1'b0,
    ST_PAYLOAD = 1'b1
  } seqState_t;

  typedef struct packed {
    logic emitIdle;
    logic emitSop;
    logic emitPay;
    logic lastBeat;
    logic usePattern;
  } seqStrobe_t;

endpackage

// File: rtl/frame_seq_ctrl.sv
module frame_seq_ctrl
  import frame_seq_pkg::*;
#(
  parameter int BEATS = 120,
  parameter int LVL_W = 9
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             srcSelPattern,
  input  logic             autoMode,
  input  logic             hostReq,
  input  logic             encReady,
  input  logic [LVL_W-1:0] fifoLevel,
  output seqStrobe_t       strobe,
  output logic             fifoRd
);

  localparam int CNT_W = $clog2(BEATS + 1);
  localparam logic [LVL_W-1:0] NEED_LVL = LVL_W'(BEATS);
  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(BEATS - 1);

  seqState_t        state;
  logic [CNT_W-1:0] beatIdx;
  logic             pending;
  logic             patLatched;
  logic             dataOk;
  logic             wantGo;
  logic             launch;
  logic             lastBeat;

  always_comb begin
    dataOk   = srcSelPattern || (fifoLevel >= NEED_LVL);
    wantGo   = autoMode || pending || hostReq;
    launch   = (state == ST_IDLE) && encReady && dataOk && wantGo;
    lastBeat = (state == ST_PAYLOAD) && (beatIdx == LAST_IDX);

    strobe.emitSop    = launch;
    strobe.emitIdle   = (state == ST_IDLE) && !launch;
    strobe.emitPay    = (state == ST_PAYLOAD);
    strobe.lastBeat   = lastBeat;
    strobe.usePattern = patLatched;
    fifoRd            = (state == ST_PAYLOAD) && !patLatched;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state      <= ST_IDLE;
      beatIdx    <= '0;
      pending    <= 1'b0;
      patLatched <= 1'b0;
    end else begin
      pending <= (pending || hostReq) && !launch;
      case (state)
        ST_IDLE: begin
          if (launch) begin
            state      <= ST_PAYLOAD;
            beatIdx    <= '0;
            patLatched <= srcSelPattern;
          end
        end
        default: begin
          if (lastBeat) begin
            state   <= ST_IDLE;
            beatIdx <= '0;
          end else begin
            beatIdx <= beatIdx + 1'b1;
          end
        end
      endcase
    end
  end

endmodule

// File: rtl/frame_seq_dpath.sv
module frame_seq_dpath
  import frame_seq_pkg::*;
#(
  parameter int              SYM_W      = 8,
  parameter int              LANES      = 2,
  parameter int              LAST_LANES = 1,
  parameter logic [SYM_W-1:0] SOP_SYM   = 8'hFB,
  parameter logic [SYM_W-1:0] COMMA_SYM = 8'hBC
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  seqStrobe_t             strobe,
  input  logic [LANES*SYM_W-1:0] fifoData,
  output logic [LANES*SYM_W-1:0] txData,
  output logic [LANES-1:0]       txIsK,
  output logic [LANES-1:0]       txValid
);

  localparam int DW = LANES * SYM_W;

  logic [SYM_W-1:0] patBase;
  logic [DW-1:0]    nextData;
  logic [LANES-1:0] nextK;
  logic [LANES-1:0] nextV;
  logic [DW-1:0]    idleBeat;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    localparam bit IN_LAST = (i < LAST_LANES);
    localparam logic [SYM_W-1:0] CTRL_SYM = (i == 0) ? SOP_SYM : COMMA_SYM;
    logic             keep;
    logic [SYM_W-1:0] payVal;

    assign keep   = !strobe.lastBeat || IN_LAST;
    assign payVal = strobe.usePattern ? (patBase + SYM_W'(i))
                                      : fifoData[i*SYM_W +: SYM_W];
    assign idleBeat[i*SYM_W +: SYM_W] = COMMA_SYM;

    assign nextData[i*SYM_W +: SYM_W] =
        strobe.emitSop ? CTRL_SYM :
        strobe.emitPay ? (keep ? payVal : '0) :
                         COMMA_SYM;
    assign nextK[i] = !strobe.emitPay;
    assign nextV[i] = strobe.emitPay && keep;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      txData  <= idleBeat;
      txIsK   <= '1;
      txValid <= '0;
      patBase <= '0;
    end else begin
      txData  <= nextData;
      txIsK   <= nextK;
      txValid <= nextV;
      if (strobe.emitPay && strobe.usePattern) begin
        patBase <= patBase + (strobe.lastBeat ? SYM_W'(LAST_LANES) : SYM_W'(LANES));
      end
    end
  end

endmodule

// File: rtl/frame_sequencer.sv
module frame_sequencer
  import frame_seq_pkg::*;
#(
  parameter int               SYM_W     = 8,
  parameter int               LANES     = 2,
  parameter int               PKT_SYMS  = 239,
  parameter int               LVL_W     = 9,
  parameter logic [SYM_W-1:0] SOP_SYM   = 8'hFB,
  parameter logic [SYM_W-1:0] COMMA_SYM = 8'hBC
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   srcSelPattern,
  input  logic                   autoMode,
  input  logic                   hostReq,
  input  logic                   encReady,
  input  logic [LANES*SYM_W-1:0] fifoData,
  input  logic [LVL_W-1:0]       fifoLevel,
  output logic                   fifoRd,
  output logic [LANES*SYM_W-1:0] txData,
  output logic [LANES-1:0]       txIsK,
  output logic [LANES-1:0]       txValid
);

  localparam int BEATS      = (PKT_SYMS + LANES - 1) / LANES;
  localparam int LAST_LANES = PKT_SYMS - (BEATS - 1) * LANES;

  seqStrobe_t strobe;

  frame_seq_ctrl #(
    .BEATS (BEATS),
    .LVL_W (LVL_W)
  ) u_ctrl (
    .clk           (clk),
    .rstN          (rstN),
    .srcSelPattern (srcSelPattern),
    .autoMode      (autoMode),
    .hostReq       (hostReq),
    .encReady      (encReady),
    .fifoLevel     (fifoLevel),
    .strobe        (strobe),
    .fifoRd        (fifoRd)
  );

  frame_seq_dpath #(
    .SYM_W      (SYM_W),
    .LANES      (LANES),
    .LAST_LANES (LAST_LANES),
    .SOP_SYM    (SOP_SYM),
    .COMMA_SYM  (COMMA_SYM)
  ) u_dpath (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .fifoData (fifoData),
    .txData   (txData),
    .txIsK    (txIsK),
    .txValid  (txValid)
  );

endmodule

// File: rtl/frame_sequencer_chk.sv
module frame_sequencer_chk #(
  parameter int               SYM_W      = 8,
  parameter int               LANES      = 2,
  parameter int               BEATS      = 120,
  parameter int               LAST_LANES = 1,
  parameter int               LVL_W      = 9,
  parameter logic [SYM_W-1:0] SOP_SYM    = 8'hFB
) (
  input logic                   clk,
  input logic                   rstN,
  input logic                   encReady,
  input logic [LVL_W-1:0]       fifoLevel,
  input logic                   fifoRd,
  input logic [LANES*SYM_W-1:0] txData,
  input logic [LANES-1:0]       txIsK,
  input logic [LANES-1:0]       txValid
);

  localparam logic [LANES-1:0] LAST_MASK = LANES'((1 << LAST_LANES) - 1);
  localparam logic [LANES-1:0] FULL_MASK = '1;

  logic isSop;
  assign isSop = txIsK[0] && (txData[SYM_W-1:0] == SOP_SYM);

  a_r2_idle_all_k: assert property (@(posedge clk) disable iff (!rstN)
    (txValid == '0) |-> (txIsK == '1));

  a_r4_payload_no_k: assert property (@(posedge clk) disable iff (!rstN)
    (txValid != '0) |-> (txIsK == '0));

  a_r4_mask_shape: assert property (@(posedge clk) disable iff (!rstN)
    (txValid != '0) |-> (txValid == FULL_MASK || txValid == LAST_MASK));

  a_r4_sop_then_payload: assert property (@(posedge clk) disable iff (!rstN)
    isSop |=> (txValid == FULL_MASK));

  a_r4_last_then_stop: assert property (@(posedge clk) disable iff (!rstN)
    (txValid == LAST_MASK && LAST_MASK != FULL_MASK) |=> (txValid == '0));

  a_r3_sop_after_ready: assert property (@(posedge clk) disable iff (!rstN)
    isSop |-> $past(encReady));

  a_r5_read_feeds_beat: assert property (@(posedge clk) disable iff (!rstN)
    fifoRd |=> (txValid != '0));

  a_r9_level_at_start: assert property (@(posedge clk) disable iff (!rstN)
    (isSop && fifoRd) |-> (fifoLevel >= LVL_W'(BEATS)));

endmodule

bind frame_sequencer frame_sequencer_chk #(
  .SYM_W      (SYM_W),
  .LANES      (LANES),
  .BEATS      (BEATS),
  .LAST_LANES (LAST_LANES),
  .LVL_W      (LVL_W),
  .SOP_SYM    (SOP_SYM)
) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .encReady  (encReady),
  .fifoLevel (fifoLevel),
  .fifoRd    (fifoRd),
  .txData    (txData),
  .txIsK     (txIsK),
  .txValid   (txValid)
);

// File: tb/tb_frame_sequencer.sv
`timescale 1ns/1ps
module tb_frame_sequencer;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        srcSelPattern = 1'b0;
  logic        autoMode = 1'b0;
  logic        hostReq = 1'b0;
  logic        encReady = 1'b0;
  logic [15:0] fifoData = 16'h0;
  logic [8:0]  fifoLevel = 9'd0;
  logic        fifoRd;
  logic [15:0] txData;
  logic [1:0]  txIsK;
  logic [1:0]  txValid;

  always #4 clk = ~clk;

  frame_sequencer dut (
    .clk(clk), .rstN(rstN), .srcSelPattern(srcSelPattern), .autoMode(autoMode),
    .hostReq(hostReq), .encReady(encReady), .fifoData(fifoData),
    .fifoLevel(fifoLevel), .fifoRd(fifoRd), .txData(txData),
    .txIsK(txIsK), .txValid(txValid)
  );

  int checks = 0;
  int fails = 0;
  int sopCount = 0;
  int cycles = 0;
  bit done = 0;
  bit modelOn = 0;

  logic [15:0] fifoQ[$];

  // behavioural reference state
  int          mPhase = 0;
  int          mBeat = 0;
  bit          mPend = 0;
  bit          mPatSel = 0;
  logic [7:0]  mPat = 8'd0;
  logic [15:0] expD = 16'hBCBC;
  logic [1:0]  expK = 2'b11;
  logic [1:0]  expV = 2'b00;
  string       expTag = "R1";

  task automatic check(bit ok, string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h at cycle %0d", tag, what, act, exp, cycles);
    end
  endtask

  task automatic pushWord(logic [15:0] w);
    fifoQ.push_back(w);
    fifoLevel = 9'(fifoQ.size());
    fifoData  = fifoQ[0];
  endtask

  // reference model and buffer, updated at the active edge
  always @(posedge clk) begin
    logic [7:0] lo, hi;
    bit go;
    cycles++;
    if (!rstN) begin
      mPhase = 0; mBeat = 0; mPend = 0; mPatSel = 0; mPat = 8'd0;
      expD = 16'hBCBC; expK = 2'b11; expV = 2'b00; expTag = "R1";
    end else if (mPhase == 0) begin
      go = encReady && (srcSelPattern || fifoLevel >= 9'd120) && (autoMode || mPend || hostReq);
      if (go) begin
        expD = 16'hBCFB; expK = 2'b11; expV = 2'b00; expTag = "R3";
        mPhase = 1; mBeat = 0; mPatSel = srcSelPattern; mPend = 0;
      end else begin
        expD = 16'hBCBC; expK = 2'b11; expV = 2'b00; expTag = "R2";
        mPend = mPend || hostReq;
      end
    end else begin
      mPend = mPend || hostReq;
      if (mPatSel) begin lo = mPat; hi = mPat + 8'd1; end
      else begin lo = fifoData[7:0]; hi = fifoData[15:8]; end
      expK = 2'b00;
      if (mBeat == 119) begin
        expD = {8'h00, lo}; expV = 2'b01; expTag = "R4";
        if (mPatSel) mPat = mPat + 8'd1;
        mPhase = 0;
      end else begin
        expD = {hi, lo}; expV = 2'b11; expTag = mPatSel ? "R6" : "R5";
        if (mPatSel) mPat = mPat + 8'd2;
      end
      mBeat++;
    end
    if (rstN && fifoRd && fifoQ.size() > 0) void'(fifoQ.pop_front());
  end

  // comparison away from the active edge
  always @(negedge clk) begin
    if (modelOn && rstN) begin
      check(txData == expD && txIsK == expK && txValid == expV, expTag, "beat {data,k,valid}",
            {12'h0, txData, txIsK, txValid}, {12'h0, expD, expK, expV});
      check(fifoRd == (mPhase == 1 && !mPatSel), "R5", "fifoRd",
            {31'h0, fifoRd}, {31'h0, (mPhase == 1 && !mPatSel)});
      if (txIsK[0] && txData[7:0] == 8'hFB) sopCount++;
    end
    fifoLevel = 9'(fifoQ.size());
    fifoData  = (fifoQ.size() > 0) ? fifoQ[0] : 16'h0;
  end

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    if (cycles > 100000) begin
      fails++; checks++;
      $display("FAIL watchdog expired actual=%0d expected<=100000", cycles);
      finishRun();
    end
  end

  task automatic waitN(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    int base;
    waitN(3);
    // R1: reset state
    check(txData == 16'hBCBC && txIsK == 2'b11 && txValid == 2'b00 && !fifoRd, "R1",
          "reset beat", {15'h0, txData, txIsK, txValid, fifoRd}, {15'h0, 16'hBCBC, 2'b11, 2'b00, 1'b0});
    rstN = 1'b1;
    modelOn = 1;

    // R7: host mode, no request, nothing launches
    srcSelPattern = 1'b1; autoMode = 1'b0; encReady = 1'b1;
    waitN(20);
    check(sopCount == 0, "R7", "frames without request", sopCount, 0);

    // R3: request held while encoder not ready
    encReady = 1'b0; hostReq = 1'b1;
    waitN(1);
    hostReq = 1'b0;
    waitN(15);
    check(sopCount == 0, "R3", "frames while not ready", sopCount, 0);
    encReady = 1'b1;
    waitN(3);
    check(sopCount == 1, "R7", "held request launched", sopCount, 1);

    // R10 and R7: mid-frame request and input changes
    waitN(30);
    hostReq = 1'b1;
    waitN(1);
    hostReq = 1'b0; srcSelPattern = 1'b0; encReady = 1'b0; autoMode = 1'b1;
    for (int i = 0; i < 10; i++) begin
      waitN(1);
      check(!fifoRd && txValid == 2'b11, "R10", "frame unaffected by input change",
            {29'h0, fifoRd, txValid}, {29'h0, 1'b0, 2'b11});
    end
    srcSelPattern = 1'b1; encReady = 1'b1; autoMode = 1'b0;
    waitN(220);
    check(sopCount == 2, "R7", "request during frame gives one more frame", sopCount, 2);

    // R9: buffer source needs a full frame of words
    srcSelPattern = 1'b0; autoMode = 1'b1;
    for (int i = 0; i < 119; i++) pushWord({8'(i * 7 + 3), 8'(i * 13 + 1)});
    waitN(20);
    check(sopCount == 2, "R9", "no launch on 119 words", sopCount, 2);
    pushWord(16'hA55A);
    waitN(130);
    check(sopCount == 3, "R8", "auto launch at 120 words", sopCount, 3);

    // R8: back-to-back frames from buffer
    for (int i = 0; i < 240; i++) pushWord({8'(i * 5 + 9), 8'(i * 3 + 2)});
    waitN(260);
    check(sopCount == 5, "R8", "two back-to-back auto frames", sopCount, 5);

    // R3 and R8: pattern auto mode gated by ready
    srcSelPattern = 1'b1; encReady = 1'b0;
    base = sopCount;
    waitN(20);
    check(sopCount == base, "R3", "no auto launch while not ready", sopCount, base);
    encReady = 1'b1;
    waitN(1);
    autoMode = 1'b0;
    waitN(4);
    check(sopCount == base + 1, "R8", "auto launch once ready", sopCount, base + 1);
    waitN(140);
    check(sopCount == base + 1, "R7", "no further frames in host mode", sopCount, base + 1);

    finishRun();
  end

endmodule